// File: doc/BRIEF.md
# RFID Tag Frame Parser

This block takes a stream of already-recovered bits, one per strobe, and extracts a 64-bit read-only RFID tag frame. It first hunts for a run of nine consecutive ones, which mark the start of a frame. It then groups the following 50 bits into ten rows. Each row holds four data bits, most significant first, and one even-parity bit. Five trailer bits follow: four column parity bits and a stop bit.

While the rows arrive, the parser builds a 40-bit tag one nibble at a time. It checks each row's parity as soon as that row's parity bit arrives. It also keeps a running parity for each of the four nibble bit positions. When the stop bit arrives, it compares the running column parities with the received trailer bits. It publishes the tag with a one-cycle valid pulse only if every row check passed, every column check passed and the stop bit is 0. Every frame end raises a done pulse, whatever the outcome, along with per-check failure flags. The parser then clears its working state and hunts for the next header.

The surrounding logic supplies `bit_valid`/`bit_in` from a line decoder and reads the tag when `tag_valid` pulses. Clock recovery and line decoding are outside this block.

Top module: `rfid_tag_parser`

## Requirements
- R1: While reset is asserted and after it is released, all pulse outputs and flags are 0, `tag_out` is 0, and the parser is hunting for a header.
- R2: Nine consecutive strobed 1 bits during header hunting form the header. The bit strobed after the ninth 1 is the first data bit of row 0.
- R3: A strobed 0 during header hunting restarts the count of consecutive ones from zero.
- R4: Each row is four data bits followed by one even-parity bit. The parity bit must equal the XOR of the four data bits. If it does not, `row_perr` pulses in the cycle after that parity bit's strobe.
- R5: Data bits are assembled MSB first. The nibble of row 0 lands in `tag_out[39:36]` and the nibble of row 9 in `tag_out[3:0]`.
- R6: The trailer's first four bits are the column parities for nibble bits 3, 2, 1 and 0, in that order. `col_err[k]` is set at frame end when the XOR of bit k over all ten nibbles differs from the received column bit.
- R7: The fifth trailer bit is the stop bit. It is reported on `stop_bit` at frame end, and a value of 1 makes the frame invalid.
- R8: `tag_valid` pulses for one cycle, and `tag_out` takes the new tag, only when no row error, no column error and a 0 stop bit hold together. Otherwise `frame_err` is set and `tag_out` keeps its previous value.
- R9: After every frame end, good or bad, row, column and tag state are cleared and the parser hunts for a new header. Bits without a header produce no frame.
- R10: Cycles with `bit_valid` low have no effect, whatever `bit_in` carries.
- R11: `frame_done`, `row_err`, `col_err`, `frame_err` and `stop_bit` update in the cycle after the stop bit's strobe. The flags hold until the next frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_valid | input | 1 | Strobe: `bit_in` carries a bit this cycle |
| bit_in | input | 1 | Recovered serial bit |
| tag_valid | output | 1 | One-cycle pulse: a checked tag is on `tag_out` |
| tag_out | output | 40 | Last valid tag, row 0 nibble in the top bits |
| frame_done | output | 1 | One-cycle pulse at every frame end |
| row_perr | output | 1 | One-cycle pulse after a row with bad parity |
| row_err | output | 1 | Last frame had at least one row parity failure |
| col_err | output | 4 | Last frame's column mismatches, bit k for nibble bit k |
| frame_err | output | 1 | Last frame failed any check |
| stop_bit | output | 1 | Stop bit value of the last frame |

## Verification
Every output of this block is registered. Each result is therefore due exactly one clock after the strobe that completes it: the ninth header one, a row's parity bit, or the stop bit. A gap in strobes never delays a result. The bench drives each strobe at a falling edge. At that same point it advances a behavioural model that holds the frame in a queue, so the model's expected outputs refer to the following rising edge. At the next falling edge the bench compares every output with the model, on every clock including idle ones. A pulse that arrives one cycle early or late therefore shows up as a miscompare.

// File: rtl/rfid_frame_pkg.sv
package rfid_frame_pkg;
  typedef enum logic [1:0] {
    PH_HUNT  = 2'd0,
    PH_ROWS  = 2'd1,
    PH_TRAIL = 2'd2
  } phase_e;
endpackage

// File: rtl/rfid_rst_sync.sv
module rfid_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rfid_hdr_hunt.sv
module rfid_hdr_hunt #(
  parameter int HDR_ONES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hunt_en,
  input  logic bit_in,
  output logic hdr_hit
);
  localparam int CW = $clog2(HDR_ONES + 1);
  localparam logic [CW-1:0] LAST_ONE = CW'(HDR_ONES - 1);

  logic [CW-1:0] ones_q, ones_d;
  logic          ones_en;

  always_comb begin
    ones_en = hunt_en;
    hdr_hit = hunt_en && bit_in && (ones_q == LAST_ONE);
    if (!bit_in || hdr_hit) ones_d = '0;
    else                    ones_d = ones_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ones_q <= '0;
    else if (ones_en) ones_q <= ones_d;
  end
endmodule

// File: rtl/rfid_group_ctr.sv
module rfid_group_ctr #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             bit_in,
  output logic             grp_end,
  output logic [NIB_W-1:0] nib_q,
  output logic             par_q
);
  localparam int PW = $clog2(NIB_W + 1);
  localparam logic [PW-1:0] POS_CHK = PW'(NIB_W);

  logic [PW-1:0]    pos_q, pos_d;
  logic [NIB_W-1:0] nib_d;
  logic             par_d;
  logic             data_bit;

  always_comb begin
    grp_end  = step && (pos_q == POS_CHK);
    data_bit = step && (pos_q != POS_CHK);
    pos_d    = grp_end ? '0 : pos_q + PW'(1);
    nib_d    = nib_q;
    par_d    = par_q;
    if (data_bit) begin
      if (NIB_W > 1) nib_d = {nib_q[NIB_W-2:0], bit_in};
      else           nib_d = bit_in;
      par_d = par_q ^ bit_in;
    end else if (grp_end) begin
      par_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      nib_q <= '0;
      par_q <= 1'b0;
    end else if (step) begin
      pos_q <= pos_d;
      nib_q <= nib_d;
      par_q <= par_d;
    end
  end
endmodule

// File: rtl/rfid_col_acc.sv
module rfid_col_acc #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             acc_en,
  input  logic [NIB_W-1:0] nib,
  output logic [NIB_W-1:0] col_q
);
  for (genvar i = 0; i < NIB_W; i++) begin : g_col
    logic col_d;
    logic col_en;

    always_comb begin
      col_en = clr || acc_en;
      col_d  = clr ? 1'b0 : (col_q[i] ^ nib[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      col_q[i] <= 1'b0;
      else if (col_en) col_q[i] <= col_d;
    end
  end
endmodule

// File: rtl/rfid_tag_parser.sv
module rfid_tag_parser
  import rfid_frame_pkg::*;
#(
  parameter int HDR_ONES = 9,
  parameter int NIB_W    = 4,
  parameter int ROWS     = 10,
  localparam int TAG_W   = NIB_W * ROWS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             bit_in,
  output logic             tag_valid,
  output logic [TAG_W-1:0] tag_out,
  output logic             frame_done,
  output logic             row_perr,
  output logic             row_err,
  output logic [NIB_W-1:0] col_err,
  output logic             frame_err,
  output logic             stop_bit
);
  localparam int RC_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [RC_W-1:0] LAST_ROW = RC_W'(ROWS - 1);

  logic rst_sync_n;

  rfid_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  phase_e           phase_q, phase_d;
  logic [RC_W-1:0]  row_q, row_d;
  logic [TAG_W-1:0] acc_q, acc_d;
  logic             bad_q, bad_d;

  logic             hunt_en, hdr_hit, step, grp_end, par_q;
  logic [NIB_W-1:0] nib_q, col_q, col_mis;
  logic             row_end, frame_end, row_mis, frame_ok;

  assign hunt_en = bit_valid && (phase_q == PH_HUNT);
  assign step    = bit_valid && (phase_q != PH_HUNT);

  rfid_hdr_hunt #(.HDR_ONES(HDR_ONES)) u_hunt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .hunt_en (hunt_en),
    .bit_in  (bit_in),
    .hdr_hit (hdr_hit)
  );

  rfid_group_ctr #(.NIB_W(NIB_W)) u_grp (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .step    (step),
    .bit_in  (bit_in),
    .grp_end (grp_end),
    .nib_q   (nib_q),
    .par_q   (par_q)
  );

  rfid_col_acc #(.NIB_W(NIB_W)) u_col (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr    (frame_end),
    .acc_en (row_end),
    .nib    (nib_q),
    .col_q  (col_q)
  );

  // Frame decode: group end means parity bit in rows, stop bit in trailer
  always_comb begin
    row_end   = grp_end && (phase_q == PH_ROWS);
    frame_end = grp_end && (phase_q == PH_TRAIL);
    row_mis   = row_end && (par_q ^ bit_in);
    col_mis   = col_q ^ nib_q;
    frame_ok  = !bad_q && (col_mis == '0) && !bit_in;

    phase_d = phase_q;
    row_d   = row_q;
    unique case (phase_q)
      PH_HUNT:  if (hdr_hit) phase_d = PH_ROWS;
      PH_ROWS:  if (row_end) begin
                  if (row_q == LAST_ROW) begin
                    phase_d = PH_TRAIL;
                    row_d   = '0;
                  end else begin
                    row_d = row_q + RC_W'(1);
                  end
                end
      PH_TRAIL: if (frame_end) phase_d = PH_HUNT;
      default:  phase_d = PH_HUNT;
    endcase

    acc_d = acc_q;
    if (frame_end)    acc_d = '0;
    else if (row_end) acc_d = (TAG_W > NIB_W) ? {acc_q[TAG_W-NIB_W-1:0], nib_q}
                                              : TAG_W'(nib_q);
    bad_d = frame_end ? 1'b0 : (bad_q || row_mis);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase_q <= PH_HUNT;
      row_q   <= '0;
      acc_q   <= '0;
      bad_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (row_end) row_q <= row_d;
      if (row_end || frame_end) begin
        acc_q <= acc_d;
        bad_q <= bad_d;
      end
    end
  end

  // Registered results, one clock after the completing strobe
  logic tag_ld;
  assign tag_ld = frame_end && frame_ok;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tag_valid  <= 1'b0;
      frame_done <= 1'b0;
      row_perr   <= 1'b0;
      tag_out    <= '0;
      row_err    <= 1'b0;
      col_err    <= '0;
      frame_err  <= 1'b0;
      stop_bit   <= 1'b0;
    end else begin
      tag_valid  <= tag_ld;
      frame_done <= frame_end;
      row_perr   <= row_mis;
      if (tag_ld) tag_out <= acc_q;
      if (frame_end) begin
        row_err   <= bad_q;
        col_err   <= col_mis;
        frame_err <= !frame_ok;
        stop_bit  <= bit_in;
      end
    end
  end
endmodule

// File: rtl/rfid_tag_parser_chk.sv
module rfid_tag_parser_chk
  import rfid_frame_pkg::*;
#(
  parameter int TAG_W = 40,
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_valid,
  input logic             tag_valid,
  input logic [TAG_W-1:0] tag_out,
  input logic             frame_done,
  input logic             row_perr,
  input logic             row_err,
  input logic [NIB_W-1:0] col_err,
  input logic             frame_err,
  input logic             stop_bit,
  input phase_e           phase
);
  // R8
  valid_has_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid |-> frame_done);
  // R8
  valid_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid |-> !frame_err);
  // R8
  fail_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && (row_err || (col_err != '0))) |-> frame_err);
  // R7
  stop_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && stop_bit) |-> (frame_err && !tag_valid));
  // R5
  tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_valid |-> $stable(tag_out));
  // R4
  perr_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_perr |-> $past(bit_valid));
  // R11
  done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(bit_valid));
  // R9
  done_rehunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (phase == PH_HUNT));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

bind rfid_tag_parser rfid_tag_parser_chk #(.TAG_W(TAG_W), .NIB_W(NIB_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bit_valid  (bit_valid),
  .tag_valid  (tag_valid),
  .tag_out    (tag_out),
  .frame_done (frame_done),
  .row_perr   (row_perr),
  .row_err    (row_err),
  .col_err    (col_err),
  .frame_err  (frame_err),
  .stop_bit   (stop_bit),
  .phase      (phase_q)
);

// File: tb/rfid_tag_parser_tb_top.sv
module rfid_tag_parser_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_valid = 1'b0;
  logic        bit_in = 1'b0;
  logic        tag_valid, frame_done, row_perr, row_err, frame_err, stop_bit;
  logic [39:0] tag_out;
  logic [3:0]  col_err;

  always #4 clk = ~clk;

  rfid_tag_parser dut_i (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .tag_valid(tag_valid), .tag_out(tag_out), .frame_done(frame_done),
    .row_perr(row_perr), .row_err(row_err), .col_err(col_err),
    .frame_err(frame_err), .stop_bit(stop_bit)
  );

  int n_chk = 0;
  int n_bad = 0;
  int n_valid_seen = 0;

  // reference model state
  bit          m_hunt = 1'b1;
  int          m_ones = 0;
  bit          m_badrow = 1'b0;
  int          q[$];
  bit          e_valid = 0, e_done = 0, e_rperr = 0, e_rerr = 0, e_ferr = 0, e_stop = 0;
  logic [39:0] e_tag = '0;
  logic [3:0]  e_cerr = '0;
  int          fb[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare();
    if (tag_valid === 1'b1) n_valid_seen++;
    chk(tag_valid === e_valid,  "R8 tag_valid", 64'(tag_valid), 64'(e_valid));
    chk(tag_out === e_tag,      "R5 tag_out",   64'(tag_out), 64'(e_tag));
    chk(frame_done === e_done,  "R11 frame_done", 64'(frame_done), 64'(e_done));
    chk(row_perr === e_rperr,   "R4 row_perr",  64'(row_perr), 64'(e_rperr));
    chk(row_err === e_rerr,     "R4 row_err",   64'(row_err), 64'(e_rerr));
    chk(col_err === e_cerr,     "R6 col_err",   64'(col_err), 64'(e_cerr));
    chk(frame_err === e_ferr,   "R8 frame_err", 64'(frame_err), 64'(e_ferr));
    chk(stop_bit === e_stop,    "R7 stop_bit",  64'(stop_bit), 64'(e_stop));
  endtask

  task automatic model_step(input bit v, input bit b);
    e_valid = 0; e_done = 0; e_rperr = 0;
    if (!v) return;
    if (m_hunt) begin
      m_ones = b ? m_ones + 1 : 0;
      if (m_ones == 9) begin m_hunt = 0; m_ones = 0; q.delete(); end
      return;
    end
    q.push_back(int'(b));
    if (q.size() <= 50 && q.size() % 5 == 0) begin
      int r = q.size() / 5 - 1;
      int p = q[r*5] ^ q[r*5+1] ^ q[r*5+2] ^ q[r*5+3];
      if (p != int'(b)) begin e_rperr = 1; m_badrow = 1; end
    end
    if (q.size() == 55) begin
      logic [39:0] t = '0;
      logic [3:0]  ce = '0;
      bit ok;
      for (int r = 0; r < 10; r++)
        t = {t[35:0], 1'(q[r*5]), 1'(q[r*5+1]), 1'(q[r*5+2]), 1'(q[r*5+3])};
      for (int k = 0; k < 4; k++) begin
        int x = q[50+k];
        for (int r = 0; r < 10; r++) x ^= q[r*5+k];
        ce[3-k] = 1'(x);
      end
      ok = !m_badrow && ce == 0 && q[54] == 0;
      e_done = 1; e_rerr = m_badrow; e_cerr = ce; e_stop = 1'(q[54]); e_ferr = !ok;
      if (ok) begin e_valid = 1; e_tag = t; end
      m_hunt = 1; m_badrow = 0; q.delete();
    end
  endtask

  task automatic cyc(input bit v, input bit b);
    @(negedge clk);
    compare();
    bit_valid = v; bit_in = b;
    model_step(v, b);
  endtask

  // frame bits into fb: header, rows MSB first, column bits for nibble bit 3..0, stop
  task automatic build(input logic [39:0] t, input int frow, input int fcol, input bit stopv, input bit hdr);
    logic [3:0] cp = '0;
    fb.delete();
    if (hdr) for (int i = 0; i < 9; i++) fb.push_back(1);
    for (int r = 0; r < 10; r++) begin
      logic [3:0] n = t[39-4*r -: 4];
      for (int k = 3; k >= 0; k--) fb.push_back(int'(n[k]));
      fb.push_back(int'(^n) ^ int'(r == frow));
      cp ^= n;
    end
    for (int k = 3; k >= 0; k--) fb.push_back(int'(cp[k]) ^ int'(k == fcol));
    fb.push_back(int'(stopv));
  endtask

  task automatic send(input int gap);
    foreach (fb[i]) begin
      cyc(1'b1, 1'(fb[i]));
      for (int g = 0; g < gap; g++) cyc(1'b0, 1'($urandom));
    end
    cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0);
    // R1 reset state
    chk(tag_valid === 0 && frame_done === 0 && tag_out === '0 && frame_err === 0,
        "R1 reset outputs", 64'(tag_out), 64'd0);

    // R2 R5 good frame
    base = n_valid_seen;
    build(40'h0123456789, -1, -1, 1'b0, 1'b1); send(0);
    chk(n_valid_seen == base + 1, "R2 header then valid", 64'(n_valid_seen - base), 64'd1);
    chk(tag_out === 40'h0123456789, "R5 tag order", 64'(tag_out), 64'h0123456789);

    // R4 row parity error in row 3
    base = n_valid_seen;
    build(40'hA5A5A5A5A5, 3, -1, 1'b0, 1'b1); send(0);
    chk(n_valid_seen == base && row_err === 1, "R4 row error blocks tag", 64'(row_err), 64'd1);

    // R6 column error on bit 1
    build(40'hFEDCBA9876, -1, 1, 1'b0, 1'b1); send(0);
    chk(col_err === 4'b0010, "R6 column bit 1", 64'(col_err), 64'h2);

    // R7 stop bit set
    build(40'h1111111111, -1, -1, 1'b1, 1'b1); send(0);
    chk(stop_bit === 1 && frame_err === 1, "R7 stop bit 1 fails", 64'(frame_err), 64'd1);
    chk(tag_out === 40'h0123456789, "R8 tag held on failure", 64'(tag_out), 64'h0123456789);

    // R3 eight ones then a zero, then a real frame
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b1);
    cyc(1'b1, 1'b0);
    base = n_valid_seen;
    build(40'h3C3C3C3C3C, -1, -1, 1'b0, 1'b1); send(0);
    chk(n_valid_seen == base + 1 && tag_out === 40'h3C3C3C3C3C, "R3 count restarts",
        64'(tag_out), 64'h3C3C3C3C3C);

    // R9 body without header gives nothing; next framed tag is good
    base = n_valid_seen;
    build(40'h0202020202, -1, -1, 1'b0, 1'b0); send(0);
    chk(n_valid_seen == base, "R9 no header no frame", 64'(n_valid_seen - base), 64'd0);
    build(40'h0202020202, -1, -1, 1'b0, 1'b1); send(0);
    chk(n_valid_seen == base + 1, "R9 clean restart", 64'(n_valid_seen - base), 64'd1);

    // R10 idle gaps with noise on bit_in
    base = n_valid_seen;
    build(40'h9ABCDEF012, -1, -1, 1'b0, 1'b1); send(3);
    chk(n_valid_seen == base + 1 && tag_out === 40'h9ABCDEF012, "R10 gaps ignored",
        64'(tag_out), 64'h9ABCDEF012);

    // random frames, model compared every clock
    for (int f = 0; f < 40; f++) begin
      logic [39:0] t = {8'($urandom), $urandom};
      int sel = $urandom_range(0, 4);
      build(t, sel == 1 ? $urandom_range(0, 9) : -1, sel == 2 ? $urandom_range(0, 3) : -1,
            sel == 3, 1'b1);
      send($urandom_range(0, 1));
    end
    finish_run();
  end
endmodule